// File: doc/BRIEF.md
# Saturating Discrete Integral Voltage Compensator

This block is the control-law core of a digitally regulated step-down converter. Once per switching period (nominally 100 kHz) a strobe presents a signed error code: the reference minus the sensed output voltage, already sampled and quantized at 1/64 V per code. The block limits the error to a window of plus or minus 1 V. It adds the limited error to an integrator with no delay, so the newest sample counts in the same update. It then scales the integrator state by a fixed gain into an unsigned 10-bit duty-cycle command for a pulse-width modulator.

The nominal loop gain is 0.01 duty per volt-sample. In duty codes (1/1024 of the period) per error code this is 0.16, built as a multiply by 41 followed by a right shift of 8. The integrator state is held inside the band that maps onto the permitted duty range, so it cannot wind up during start-up or overload. When regulation is reached the error settles to exactly zero and the command stops moving.

Top module: `sat_int_compensator`

## Requirements
- R1: A synchronous active-high reset clears the integrator state to 0, drives `duty_o` to 0 and deasserts `duty_vld_o`.
- R2: `duty_vld_o` is high in exactly the cycle after each clock edge that samples `sample_i` high, and is low otherwise.
- R3: `err_i` is an 8-bit two's complement code with 1 LSB = 1/64 V. Values above +64 are used as +64 and values below -64 are used as -64, so one update moves the state by at most 64.
- R4: The integrator has no delay: on a strobe, state[n] = state[n-1] + e[n], and the command registered on that edge already includes e[n].
- R5: The command equals floor(state * 41 / 256), a duty of code/1024 of the switching period.
- R6: The state is clamped without wrap at an upper limit of 5114, the smallest state whose command is 819 (0.8 duty), so `duty_o` never exceeds 819.
- R7: The state is clamped without wrap at a lower limit of 0. After any stay at a limit, a single sample of the opposite sign moves the state off that limit at once (no wind-up).
- R8: A strobed error of zero leaves `duty_o` unchanged.
- R9: While `sample_i` is low, `err_i` is ignored and `duty_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | One-cycle strobe, once per switching period |
| err_i | input | 8 | Signed error code, 1/64 V per LSB |
| duty_o | output | 10 | Unsigned duty command, 1/1024 per LSB |
| duty_vld_o | output | 1 | High for one cycle after each strobe |

## Verification
The hardest condition to reach from the ports is a state pinned against a limit. Proving there is no wind-up needs the state driven into a clamp and held there while further error of the same sign arrives. The bench feeds long runs of oversized error codes, which are first reduced to +64 or -64. These push the state into the upper clamp, and after that into the lower clamp. It then applies a single sample of the opposite sign and checks that the command leaves the limit in that same update.

// File: rtl/sat_int_compensator.sv
module sat_int_compensator #(
  parameter int ERR_W      = 8,
  parameter int ERR_LIM    = 64,
  parameter int ACC_W      = 16,
  parameter int GAIN_NUM   = 41,
  parameter int GAIN_SHIFT = 8,
  parameter int DUTY_W     = 10,
  parameter int DUTY_MAX   = 819,
  parameter int DUTY_MIN   = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    sample_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [DUTY_W-1:0]       duty_o,
  output logic                    duty_vld_o
);
  localparam int ACC_HI = (DUTY_MAX * (2 ** GAIN_SHIFT) + GAIN_NUM - 1) / GAIN_NUM;
  localparam int ACC_LO = (DUTY_MIN * (2 ** GAIN_SHIFT) + GAIN_NUM - 1) / GAIN_NUM;
  localparam int SUM_W  = ACC_W + 1;
  localparam int PROD_W = ACC_W + $clog2(GAIN_NUM + 1) + 1;

  localparam logic signed [ACC_W-1:0]  E_HI   = ACC_W'(ERR_LIM);
  localparam logic signed [ACC_W-1:0]  E_LO   = -E_HI;
  localparam logic signed [SUM_W-1:0]  S_HI   = SUM_W'(ACC_HI);
  localparam logic signed [SUM_W-1:0]  S_LO   = SUM_W'(ACC_LO);
  localparam logic signed [PROD_W-1:0] K      = PROD_W'(GAIN_NUM);
  localparam logic signed [PROD_W-1:0] D_HI   = PROD_W'(DUTY_MAX);
  localparam logic signed [PROD_W-1:0] D_LO   = PROD_W'(DUTY_MIN);

  logic signed [ACC_W-1:0]  err_x, err_c, acc_q, acc_nx;
  logic signed [SUM_W-1:0]  sum;
  logic signed [PROD_W-1:0] prod, scaled, lim;

  assign err_x = ACC_W'(err_i);
  assign err_c = (err_x > E_HI) ? E_HI : (err_x < E_LO) ? E_LO : err_x;

  assign sum    = {acc_q[ACC_W-1], acc_q} + {err_c[ACC_W-1], err_c};
  assign acc_nx = (sum > S_HI) ? ACC_W'(S_HI) :
                  (sum < S_LO) ? ACC_W'(S_LO) : ACC_W'(sum);

  assign prod   = PROD_W'(acc_nx) * K;
  assign scaled = prod >>> GAIN_SHIFT;
  assign lim    = (scaled > D_HI) ? D_HI : (scaled < D_LO) ? D_LO : scaled;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q      <= '0;
      duty_o     <= '0;
      duty_vld_o <= 1'b0;
    end else begin
      duty_vld_o <= sample_i;
      if (sample_i) begin
        acc_q  <= acc_nx;
        duty_o <= DUTY_W'(lim);
      end
    end
  end
endmodule

// File: rtl/sat_int_compensator_chk.sv
module sat_int_compensator_chk #(
  parameter int ERR_W      = 8,
  parameter int DUTY_W     = 10,
  parameter int DUTY_MAX   = 819,
  parameter int STEP_MAX   = 12
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    sample_i,
  input logic signed [ERR_W-1:0] err_i,
  input logic [DUTY_W-1:0]       duty_o,
  input logic                    duty_vld_o
);
  assert_vld_follows_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_i |=> duty_vld_o);
  assert_vld_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !sample_i |=> !duty_vld_o);
  assert_duty_ceiling_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(duty_o) <= DUTY_MAX);
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !sample_i |=> $stable(duty_o));
  assert_zero_err_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (sample_i && err_i == '0) |=> $stable(duty_o));
  assert_step_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    sample_i |=> (int'(duty_o) <= int'($past(duty_o)) + STEP_MAX &&
                  int'(duty_o) + STEP_MAX >= int'($past(duty_o))));
endmodule

bind sat_int_compensator sat_int_compensator_chk #(
  .ERR_W(ERR_W), .DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX),
  .STEP_MAX((ERR_LIM * GAIN_NUM + (2 ** GAIN_SHIFT) - 1) / (2 ** GAIN_SHIFT) + 1)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .sample_i(sample_i), .err_i(err_i),
  .duty_o(duty_o), .duty_vld_o(duty_vld_o)
);

// File: tb/test_sat_int_compensator.sv
module test_sat_int_compensator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample = 1'b0;
  logic signed [7:0] err = '0;
  logic [9:0] duty;
  logic vld;

  int checks = 0;
  int errors = 0;
  int acc_m  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sat_int_compensator i_sat_int_compensator (
    .clk_i(clk), .rst_i(rst), .sample_i(sample), .err_i(err),
    .duty_o(duty), .duty_vld_o(vld)
  );

  function automatic int exp_duty(int a);
    return (a * 41) / 256;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(int e, string req);
    int ec;
    ec = (e > 64) ? 64 : (e < -64) ? -64 : e;
    acc_m = acc_m + ec;
    if (acc_m > 5114) acc_m = 5114;
    if (acc_m < 0) acc_m = 0;
    @(negedge clk);
    sample = 1'b1;
    err = 8'(e);
    @(negedge clk);
    sample = 1'b0;
    err = 8'(-e);
    check(req, int'(vld), 1);
    check(req, int'(duty), exp_duty(acc_m));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    acc_m = 0;
    check("R1 duty", int'(duty), 0);
    check("R1 vld", int'(vld), 0);
  endtask

  task automatic t_basic();
    strobe(10, "R4");
    strobe(10, "R4");
    strobe(5, "R5");
    check("R5 value", int'(duty), 4);
    strobe(-3, "R4");
  endtask

  task automatic t_err_window();
    do_reset();
    strobe(127, "R3");
    check("R3 high", int'(duty), 10);
    strobe(-128, "R3");
    check("R3 low", int'(duty), 0);
    strobe(100, "R3");
    strobe(-70, "R3");
  endtask

  task automatic t_upper();
    for (int i = 0; i < 90; i++) strobe(127, "R6");
    check("R6 ceiling", int'(duty), 819);
    strobe(-64, "R7");
    check("R7 leave top", int'(duty), 808);
  endtask

  task automatic t_lower();
    for (int i = 0; i < 90; i++) strobe(-128, "R7");
    check("R7 floor", int'(duty), 0);
    strobe(1, "R7");
    strobe(10, "R7");
    check("R7 leave floor", int'(duty), 1);
  endtask

  task automatic t_zero();
    int held;
    strobe(40, "R8");
    held = int'(duty);
    strobe(0, "R8");
    check("R8 hold", int'(duty), held);
  endtask

  task automatic t_idle();
    int held;
    held = int'(duty);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      err = 8'(60 - i * 30);
      check("R2 no vld", int'(vld), 0);
      check("R9 hold", int'(duty), held);
    end
    strobe(0, "R9");
    check("R9 state kept", int'(duty), held);
    @(negedge clk);
    check("R2 single pulse", int'(vld), 0);
  endtask

  task automatic t_reset_mid();
    strobe(64, "R1");
    do_reset();
    strobe(0, "R1");
    check("R1 state cleared", int'(duty), 0);
  endtask

  initial begin
    do_reset();
    t_basic();
    t_err_window();
    t_upper();
    t_lower();
    t_zero();
    t_idle();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule